// File: doc/BRIEF.md
# Instruction Dispatch Router

This block sits at the dispatch point of an out-of-order core. Each cycle it looks at up to `SLOTS` instruction tokens from the front of the dispatch stream and decides, slot by slot and strictly in order, where each one goes. It can go to the instruction queue through a plain, a non-speculative or a barrier insertion port, to the load queue or the store queue, be completed on the spot (nops), or be dropped (tokens already squashed). Each token carries eight class flags.

Before a token is placed, the block checks the space left in the queues it needs. The check counts the free entries reported by the queues, less the entries taken by earlier slots in the same cycle. The first slot that cannot be placed ends dispatch for the cycle. It raises a stall toward the upstream stage and forces the upstream unblock indication low. The block also reports how many tokens it consumed and how many load-queue and store-queue credits go back upstream. All results are registered and appear one clock after the inputs.

Top module: `dispatch_router`

## Requirements
- R1: While reset (`rst_n` low) is applied, every output is zero.
- R2: A valid token with flag bit 0 (squashed) set is dropped (`drop_mask`). It uses no insertion port and no queue space, and it is not subject to any resource check. It still counts in `disp_count`, adds one to `lq_credit` if flag bit 1 (load) is set, and adds one to `sq_credit` if flag bit 2 (store) or bit 3 (atomic) is set.
- R3: A non-squashed token (nops included) stalls when the instruction-queue space left is zero. The space left is `iq_free` minus the earlier insertions into any instruction-queue port this cycle. The stall ends dispatch, sets `stall`, and forces `unblock_out` low.
- R4: A load stalls when the load-queue space left is zero. A store or atomic stalls when the store-queue space left is zero. Either stall has the same effect as in R3.
- R5: Slots are handled from slot 0 upward. The first invalid slot or the first stalled slot ends dispatch, and no later slot is taken. The taken slots always form a prefix.
- R6: Class precedence is atomic (bit 3), then load (bit 1), store (bit 2), barrier (bit 5), nop (bit 6), and other. An atomic takes a store-queue entry and uses the non-speculative port with `ready_mask` set.
- R7: A load takes a load-queue entry and uses the plain port. With flag bit 7 (non-speculative) set, it uses the non-speculative port with `ready_mask` set instead.
- R8: A store takes a store-queue entry and uses the plain port. With bit 4 (store-conditional) or bit 7 set, it uses the non-speculative port with `ready_mask` set instead.
- R9: A barrier uses the barrier port with `ready_mask` set and takes no load-queue or store-queue entry.
- R10: A nop sets `nop_mask` and `ready_mask`, uses no insertion port, and takes no instruction-queue space.
- R11: Any other token uses the non-speculative port with `ready_mask` set when bit 7 is set, and otherwise uses the plain port.
- R12: `disp_count` is the number of taken slots, dropped ones included. `lq_credit` counts taken loads, and `sq_credit` counts taken stores and atomics. All outputs appear one clock after the inputs that produced them.
- R13: `unblock_out` equals `unblock_in` of the same cycle when no stall occurs, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | SLOTS | Token present in each slot |
| slot_flags | input | SLOTS x 8 | Class flags per slot |
| iq_free | input | CNT_W | Free instruction-queue entries |
| lq_free | input | CNT_W | Free load-queue entries |
| sq_free | input | CNT_W | Free store-queue entries |
| unblock_in | input | 1 | Upstream unblock request of this cycle |
| plain_mask | output | SLOTS | Slots inserted through the plain port |
| nspec_mask | output | SLOTS | Slots inserted through the non-speculative port |
| barrier_mask | output | SLOTS | Slots inserted through the barrier port |
| lq_mask | output | SLOTS | Slots given a load-queue entry |
| sq_mask | output | SLOTS | Slots given a store-queue entry |
| ready_mask | output | SLOTS | Slots marked ready to commit |
| nop_mask | output | SLOTS | Slots completed at dispatch as nops |
| drop_mask | output | SLOTS | Squashed slots dropped |
| disp_count | output | clog2(SLOTS+1) | Tokens consumed |
| lq_credit | output | clog2(SLOTS+1) | Load-queue credits returned |
| sq_credit | output | clog2(SLOTS+1) | Store-queue credits returned |
| stall | output | 1 | Dispatch stopped on a resource check |
| unblock_out | output | 1 | Unblock passed upstream |

## Verification
The hardest case is a stall caused by space that earlier slots in the same cycle have used up, rather than by a queue that reports itself full. This happens, for example, with two loads and one free load entry, or with nops placed ahead of a plain token when only one instruction-queue entry is free. Directed cycles set up these cases with small free counts. A long random phase then keeps all three free counts between 0 and 3 and mixes every flag combination, so that partial dispatch, stalls behind squashed slots and interleaved classes come up often.

// File: rtl/dispatch_router_pkg.sv
package dispatch_router_pkg;

    localparam int FLAG_W   = 8;
    localparam int F_SQUASH = 0;
    localparam int F_LOAD   = 1;
    localparam int F_STORE  = 2;
    localparam int F_ATOMIC = 3;
    localparam int F_SCOND  = 4;
    localparam int F_BARR   = 5;
    localparam int F_NOP    = 6;
    localparam int F_NSPEC  = 7;

    typedef enum logic [1:0] {
        RT_NONE  = 2'd0,
        RT_PLAIN = 2'd1,
        RT_NSPEC = 2'd2,
        RT_BARR  = 2'd3
    } route_e;

    typedef struct packed {
        logic   valid;
        logic   drop;
        logic   need_lq;
        logic   need_sq;
        route_e route;
        logic   ready;
        logic   nop;
        logic   lq_cr;
        logic   sq_cr;
    } slot_info_t;

endpackage

// File: rtl/dispatch_slot_decode.sv
module dispatch_slot_decode
    import dispatch_router_pkg::*;
(
    input  logic              valid,
    input  logic [FLAG_W-1:0] flags,
    output slot_info_t        info
);

    always_comb begin
        info       = '0;
        info.route = RT_NONE;
        info.valid = valid;
        if (valid) begin
            if (flags[F_SQUASH]) begin
                info.drop  = 1'b1;
                info.lq_cr = flags[F_LOAD];
                info.sq_cr = flags[F_STORE] | flags[F_ATOMIC];
            end else if (flags[F_ATOMIC]) begin
                info.need_sq = 1'b1;
                info.sq_cr   = 1'b1;
                info.route   = RT_NSPEC;
                info.ready   = 1'b1;
            end else if (flags[F_LOAD]) begin
                info.need_lq = 1'b1;
                info.lq_cr   = 1'b1;
                info.route   = flags[F_NSPEC] ? RT_NSPEC : RT_PLAIN;
                info.ready   = flags[F_NSPEC];
            end else if (flags[F_STORE]) begin
                info.need_sq = 1'b1;
                info.sq_cr   = 1'b1;
                info.route   = (flags[F_SCOND] | flags[F_NSPEC]) ? RT_NSPEC : RT_PLAIN;
                info.ready   = flags[F_SCOND] | flags[F_NSPEC];
            end else if (flags[F_BARR]) begin
                info.route = RT_BARR;
                info.ready = 1'b1;
            end else if (flags[F_NOP]) begin
                info.nop   = 1'b1;
                info.ready = 1'b1;
            end else begin
                info.route = flags[F_NSPEC] ? RT_NSPEC : RT_PLAIN;
                info.ready = flags[F_NSPEC];
            end
        end
    end

endmodule

// File: rtl/dispatch_chain.sv
module dispatch_chain
    import dispatch_router_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int CNT_W = 4
) (
    input  slot_info_t [SLOTS-1:0] info,
    input  logic [CNT_W-1:0]       iq_free,
    input  logic [CNT_W-1:0]       lq_free,
    input  logic [CNT_W-1:0]       sq_free,
    output logic [SLOTS-1:0]       take,
    output logic                   stall
);

    logic             alive;
    logic [CNT_W-1:0] iq_left;
    logic [CNT_W-1:0] lq_left;
    logic [CNT_W-1:0] sq_left;

    always_comb begin
        take    = '0;
        stall   = 1'b0;
        alive   = 1'b1;
        iq_left = iq_free;
        lq_left = lq_free;
        sq_left = sq_free;
        for (int i = 0; i < SLOTS; i++) begin
            if (alive) begin
                if (!info[i].valid) begin
                    alive = 1'b0;
                end else if (info[i].drop) begin
                    take[i] = 1'b1;
                end else if ((iq_left == '0) ||
                             (info[i].need_lq && lq_left == '0) ||
                             (info[i].need_sq && sq_left == '0)) begin
                    alive = 1'b0;
                    stall = 1'b1;
                end else begin
                    take[i] = 1'b1;
                    if (info[i].route != RT_NONE) iq_left = iq_left - CNT_W'(1);
                    if (info[i].need_lq)          lq_left = lq_left - CNT_W'(1);
                    if (info[i].need_sq)          sq_left = sq_left - CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/dispatch_router.sv
module dispatch_router
    import dispatch_router_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int CNT_W = 4,
    localparam int CW   = $clog2(SLOTS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SLOTS-1:0]              slot_valid,
    input  logic [SLOTS-1:0][FLAG_W-1:0]  slot_flags,
    input  logic [CNT_W-1:0]              iq_free,
    input  logic [CNT_W-1:0]              lq_free,
    input  logic [CNT_W-1:0]              sq_free,
    input  logic                          unblock_in,
    output logic [SLOTS-1:0]              plain_mask,
    output logic [SLOTS-1:0]              nspec_mask,
    output logic [SLOTS-1:0]              barrier_mask,
    output logic [SLOTS-1:0]              lq_mask,
    output logic [SLOTS-1:0]              sq_mask,
    output logic [SLOTS-1:0]              ready_mask,
    output logic [SLOTS-1:0]              nop_mask,
    output logic [SLOTS-1:0]              drop_mask,
    output logic [CW-1:0]                 disp_count,
    output logic [CW-1:0]                 lq_credit,
    output logic [CW-1:0]                 sq_credit,
    output logic                          stall,
    output logic                          unblock_out
);

    typedef struct packed {
        logic [SLOTS-1:0] plain;
        logic [SLOTS-1:0] nspec;
        logic [SLOTS-1:0] barr;
        logic [SLOTS-1:0] lq;
        logic [SLOTS-1:0] sq;
        logic [SLOTS-1:0] rdy;
        logic [SLOTS-1:0] nop;
        logic [SLOTS-1:0] drop;
        logic [CW-1:0]    cnt;
        logic [CW-1:0]    lq_cr;
        logic [CW-1:0]    sq_cr;
        logic             stall;
        logic             unblk;
    } out_t;

    slot_info_t [SLOTS-1:0] info;
    logic [SLOTS-1:0]       take;
    logic                   chain_stall;
    out_t                   out_d;
    out_t                   out_q;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        dispatch_slot_decode u_dec (
            .valid (slot_valid[g]),
            .flags (slot_flags[g]),
            .info  (info[g])
        );
    end

    dispatch_chain #(
        .SLOTS (SLOTS),
        .CNT_W (CNT_W)
    ) u_chain (
        .info    (info),
        .iq_free (iq_free),
        .lq_free (lq_free),
        .sq_free (sq_free),
        .take    (take),
        .stall   (chain_stall)
    );

    always_comb begin
        out_d = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (take[i]) begin
                out_d.plain[i] = (info[i].route == RT_PLAIN);
                out_d.nspec[i] = (info[i].route == RT_NSPEC);
                out_d.barr[i]  = (info[i].route == RT_BARR);
                out_d.lq[i]    = info[i].need_lq;
                out_d.sq[i]    = info[i].need_sq;
                out_d.rdy[i]   = info[i].ready;
                out_d.nop[i]   = info[i].nop;
                out_d.drop[i]  = info[i].drop;
                out_d.cnt      = out_d.cnt + CW'(1);
                out_d.lq_cr    = out_d.lq_cr + CW'(info[i].lq_cr);
                out_d.sq_cr    = out_d.sq_cr + CW'(info[i].sq_cr);
            end
        end
        out_d.stall = chain_stall;
        out_d.unblk = unblock_in & ~chain_stall;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign plain_mask   = out_q.plain;
    assign nspec_mask   = out_q.nspec;
    assign barrier_mask = out_q.barr;
    assign lq_mask      = out_q.lq;
    assign sq_mask      = out_q.sq;
    assign ready_mask   = out_q.rdy;
    assign nop_mask     = out_q.nop;
    assign drop_mask    = out_q.drop;
    assign disp_count   = out_q.cnt;
    assign lq_credit    = out_q.lq_cr;
    assign sq_credit    = out_q.sq_cr;
    assign stall        = out_q.stall;
    assign unblock_out  = out_q.unblk;

endmodule

// File: rtl/dispatch_router_chk.sv
module dispatch_router_chk #(
    parameter int SLOTS = 4,
    parameter int CNT_W = 4,
    localparam int CW   = $clog2(SLOTS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] iq_free,
    input logic [CNT_W-1:0] lq_free,
    input logic [SLOTS-1:0] plain_mask,
    input logic [SLOTS-1:0] nspec_mask,
    input logic [SLOTS-1:0] barrier_mask,
    input logic [SLOTS-1:0] lq_mask,
    input logic [SLOTS-1:0] sq_mask,
    input logic [SLOTS-1:0] nop_mask,
    input logic [SLOTS-1:0] drop_mask,
    input logic [CW-1:0]    disp_count,
    input logic             stall,
    input logic             unblock_out
);

    logic [SLOTS-1:0] taken;
    logic [SLOTS-1:0] iq_ports;

    assign iq_ports = plain_mask | nspec_mask | barrier_mask;
    assign taken    = iq_ports | nop_mask | drop_mask;

    // R5
    prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken & (taken + SLOTS'(1))) == '0);

    // R12
    count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(disp_count) == $countones(taken));

    // R13
    unblock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !unblock_out);

    // R10
    nop_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nop_mask & iq_ports) == '0);

    // R2
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_mask & (iq_ports | lq_mask | sq_mask)) == '0);

    // R3
    iq_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && $past(rst_n) |-> $countones(iq_ports) <= int'($past(iq_free)));

    // R4
    lq_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && $past(rst_n) |-> $countones(lq_mask) <= int'($past(lq_free)));

endmodule

bind dispatch_router dispatch_router_chk #(
    .SLOTS (SLOTS),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .iq_free      (iq_free),
    .lq_free      (lq_free),
    .plain_mask   (plain_mask),
    .nspec_mask   (nspec_mask),
    .barrier_mask (barrier_mask),
    .lq_mask      (lq_mask),
    .sq_mask      (sq_mask),
    .nop_mask     (nop_mask),
    .drop_mask    (drop_mask),
    .disp_count   (disp_count),
    .stall        (stall),
    .unblock_out  (unblock_out)
);

// File: tb/dispatch_router_test.sv
module dispatch_router_test;

    localparam int W  = 4;
    localparam int CN = 4;
    localparam int CW = $clog2(W + 1);

    localparam logic [7:0] T_SQ  = 8'h01;
    localparam logic [7:0] T_LD  = 8'h02;
    localparam logic [7:0] T_ST  = 8'h04;
    localparam logic [7:0] T_AT  = 8'h08;
    localparam logic [7:0] T_SC  = 8'h10;
    localparam logic [7:0] T_BA  = 8'h20;
    localparam logic [7:0] T_NP  = 8'h40;
    localparam logic [7:0] T_NS  = 8'h80;
    localparam logic [7:0] T_ALU = 8'h00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0]       slot_valid = '0;
    logic [W-1:0][7:0]  slot_flags = '0;
    logic [CN-1:0]      iq_free = '0, lq_free = '0, sq_free = '0;
    logic               unblock_in = 1'b0;
    logic [W-1:0] plain_mask, nspec_mask, barrier_mask, lq_mask, sq_mask;
    logic [W-1:0] ready_mask, nop_mask, drop_mask;
    logic [CW-1:0] disp_count, lq_credit, sq_credit;
    logic stall, unblock_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // expected values
    logic [W-1:0] e_plain, e_nspec, e_barr, e_lq, e_sq, e_rdy, e_nop, e_drop;
    int e_cnt, e_lqcr, e_sqcr;
    bit e_stall, e_unblk;

    always #2 clk = ~clk;

    dispatch_router #(.SLOTS(W), .CNT_W(CN)) uut (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_flags(slot_flags),
        .iq_free(iq_free), .lq_free(lq_free), .sq_free(sq_free), .unblock_in(unblock_in),
        .plain_mask(plain_mask), .nspec_mask(nspec_mask), .barrier_mask(barrier_mask),
        .lq_mask(lq_mask), .sq_mask(sq_mask), .ready_mask(ready_mask), .nop_mask(nop_mask),
        .drop_mask(drop_mask), .disp_count(disp_count), .lq_credit(lq_credit),
        .sq_credit(sq_credit), .stall(stall), .unblock_out(unblock_out)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: walk the tokens like a queue of work items.
    task automatic model();
        int iql = int'(iq_free);
        int lql = int'(lq_free);
        int sql = int'(sq_free);
        bit going = 1;
        {e_plain, e_nspec, e_barr, e_lq, e_sq, e_rdy, e_nop, e_drop} = '0;
        e_cnt = 0; e_lqcr = 0; e_sqcr = 0; e_stall = 0;
        for (int i = 0; i < W; i++) begin
            logic [7:0] f;
            bit is_at, is_ld, is_st, is_ba, is_np, wl, ws;
            f = slot_flags[i];
            if (!going) continue;
            if (!slot_valid[i]) begin going = 0; continue; end
            if (f[0]) begin
                e_drop[i] = 1; e_cnt++;
                if (f[1]) e_lqcr++;
                if (f[2] || f[3]) e_sqcr++;
                continue;
            end
            is_at = f[3];
            is_ld = !is_at && f[1];
            is_st = !is_at && !is_ld && f[2];
            is_ba = !is_at && !is_ld && !is_st && f[5];
            is_np = !is_at && !is_ld && !is_st && !is_ba && f[6];
            wl = is_ld;
            ws = is_at || is_st;
            if (iql == 0 || (wl && lql == 0) || (ws && sql == 0)) begin
                e_stall = 1; going = 0; continue;
            end
            e_cnt++;
            if (wl) begin lql--; e_lq[i] = 1; e_lqcr++; end
            if (ws) begin sql--; e_sq[i] = 1; e_sqcr++; end
            if (is_np) begin
                e_nop[i] = 1; e_rdy[i] = 1;
            end else begin
                iql--;
                if (is_ba) begin
                    e_barr[i] = 1; e_rdy[i] = 1;
                end else if (is_at || f[7] || (is_st && f[4])) begin
                    e_nspec[i] = 1; e_rdy[i] = 1;
                end else begin
                    e_plain[i] = 1;
                end
            end
        end
        e_unblk = unblock_in && !e_stall;
    endtask

    task automatic compare();
        chk("R11", "plain_mask",   int'(plain_mask),   int'(e_plain));
        chk("R6",  "nspec_mask",   int'(nspec_mask),   int'(e_nspec));
        chk("R9",  "barrier_mask", int'(barrier_mask), int'(e_barr));
        chk("R7",  "lq_mask",      int'(lq_mask),      int'(e_lq));
        chk("R8",  "sq_mask",      int'(sq_mask),      int'(e_sq));
        chk("R8",  "ready_mask",   int'(ready_mask),   int'(e_rdy));
        chk("R10", "nop_mask",     int'(nop_mask),     int'(e_nop));
        chk("R2",  "drop_mask",    int'(drop_mask),    int'(e_drop));
        chk("R12", "disp_count",   int'(disp_count),   e_cnt);
        chk("R12", "lq_credit",    int'(lq_credit),    e_lqcr);
        chk("R12", "sq_credit",    int'(sq_credit),    e_sqcr);
        chk("R3",  "stall",        int'(stall),        int'(e_stall));
        chk("R13", "unblock_out",  int'(unblock_out),  int'(e_unblk));
    endtask

    // Inputs are applied at a falling edge; results are sampled one full cycle later.
    task automatic cyc(logic [W-1:0] v, logic [7:0] f0, logic [7:0] f1, logic [7:0] f2,
                       logic [7:0] f3, int iq, int lq, int sq, bit ub);
        slot_valid = v;
        slot_flags = {f3, f2, f1, f0};
        iq_free = CN'(iq); lq_free = CN'(lq); sq_free = CN'(sq);
        unblock_in = ub;
        model();
        @(negedge clk);
        compare();
    endtask

    initial begin
        #200000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        slot_valid = '1; slot_flags = {4{T_LD}}; iq_free = 4'd9; unblock_in = 1;
        @(negedge clk); @(negedge clk);
        // R1: outputs held at zero under reset
        chk("R1", "reset outputs", int'({plain_mask, nspec_mask, lq_mask, drop_mask,
            disp_count, stall, unblock_out}), 0);
        rst_n = 1'b1;

        // R11 plain flow, ample space
        cyc(4'hF, T_ALU, T_ALU, T_ALU, T_ALU, 9, 9, 9, 1);
        // R6 atomic, R7 load, R8 store and store-conditional
        cyc(4'hF, T_AT, T_LD, T_ST, T_ST | T_SC, 9, 9, 9, 0);
        // R9 barrier, R10 nop, R11 non-speculative other, R7 non-speculative load
        cyc(4'hF, T_BA, T_NP, T_ALU | T_NS, T_LD | T_NS, 9, 9, 9, 1);
        // R6 precedence: atomic+load flags route as atomic
        cyc(4'h3, T_AT | T_LD, T_NP | T_BA, T_ALU, T_ALU, 9, 9, 9, 0);
        // R2 squashed tokens bypass checks even with all queues full
        cyc(4'hF, T_SQ | T_LD, T_SQ | T_ST, T_SQ | T_AT, T_SQ, 0, 0, 0, 1);
        // R3 instruction queue space runs out inside the cycle
        cyc(4'hF, T_ALU, T_LD, T_ALU, T_ALU, 2, 9, 9, 1);
        // R3 nop still needs a nonzero instruction-queue space
        cyc(4'hF, T_NP, T_ALU, T_ALU, T_ALU, 0, 9, 9, 1);
        // R10 nops do not consume instruction-queue space
        cyc(4'hF, T_NP, T_NP, T_ALU, T_ALU, 1, 9, 9, 1);
        // R4 two loads, one load entry
        cyc(4'hF, T_LD, T_LD, T_ALU, T_ALU, 9, 1, 9, 1);
        // R4 store then atomic with one store entry
        cyc(4'hF, T_ST, T_AT, T_ALU, T_ALU, 9, 9, 1, 1);
        // R5 invalid slot ends the stream
        cyc(4'b1101, T_ALU, T_ALU, T_ALU, T_ALU, 9, 9, 9, 1);
        // R5 squashed slot behind a stall is not taken
        cyc(4'hF, T_SQ, T_LD, T_SQ | T_LD, T_ALU, 9, 0, 9, 1);
        // R12 empty cycle
        cyc(4'h0, T_ALU, T_ALU, T_ALU, T_ALU, 9, 9, 9, 1);

        for (int k = 0; k < 3000; k++) begin
            logic [7:0] r0, r1, r2, r3;
            r0 = 8'($urandom); r1 = 8'($urandom); r2 = 8'($urandom); r3 = 8'($urandom);
            if ($urandom_range(0, 3) != 0) begin r0[0] = 0; r1[0] = 0; end
            cyc(($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'hF, r0, r1, r2, r3,
                $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                1'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule